// File: doc/BRIEF.md
# Suspend Modulation Duty Controller

This block throttles a processor core by toggling an active-low suspend line with a programmable duty cycle. Each modulation period is made of a run phase, during which the line is high and the core executes, followed by a suspend phase, during which the line is low and the core idles. Both phase lengths are 8-bit counts of a fixed 32 µs tick. The tick is derived from the system clock by a prescaler whose divide ratio is a parameter. The resulting throughput is run / (run + suspend) of full speed.

Software sets the controller up through a byte-wide register port. The port holds the two phase counts, a configuration byte whose bit 0 enables modulation, a power-management enable byte, and two speedup counts in milliseconds. An interrupt event or a video-activity event can open a speedup window. While a window is open the suspend line is held high, so latency-critical work runs at full speed. Phase counts written mid-period take effect only at the next period boundary.

Top module: `susp_duty_ctrl`

## Requirements
- R1: After reset every register reads 0x00 and `susp_n` is 1. A write to 0x80 (PM enable), 0x8C (interrupt speedup ms), 0x8D (video speedup ms), 0x94 (run count), 0x95 (suspend count) or 0x96 (config) reads back the written byte on `reg_rdata` when `reg_addr` selects it. Any other address reads 0x00 and stores nothing.
- R2: With modulation enabled and both counts nonzero, `susp_n` is high for RUN×TICK_DIV cycles and then low for SUSP×TICK_DIV cycles, repeating. The tick fires once every TICK_DIV cycles, counted freely from reset, and `susp_n` changes only on a tick edge.
- R3: While config bit 0 is clear, `susp_n` stays high, and the next enable starts a fresh period with the current counts.
- R4: A suspend count of 0 keeps `susp_n` high. A run count of 0 with a nonzero suspend count keeps `susp_n` low.
- R5: Counts written during a period are applied only when that period's suspend phase ends. The phases in progress keep the old lengths.
- R6: With PM enable bit 3 set, a one-cycle `irq_evt` pulse opens a window of N×MS_TICKS ticks, where N is the value of register 0x8C. The window starts at the next clock edge, and `susp_n` is high throughout it.
- R7: With PM enable bit 4 set, a `vid_evt` pulse opens a window in the same way, using register 0x8D.
- R8: An event during an open window reloads that window to its full length. An event has no effect if its PM enable bit is clear or its speedup count is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address for read and write |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| irq_evt | input | 1 | Interrupt activity pulse |
| vid_evt | input | 1 | Video activity pulse |
| susp_n | output | 1 | Active-low suspend line to the core |

## Verification
A sweep of twelve run/suspend count pairs measures the length of each high and low phase in cycles. This shows whether the two counts are swapped, scaled wrongly or off by one tick. A rewrite in the middle of a run phase separates correct boundary latching from an immediate update, because the phase in progress must finish with its old length. Zero-count pairs and a disabled config bit exercise the constant-level cases. Single, repeated, masked and zero-length speedup events show the window length, the reload and the gating of each source.

// File: rtl/susp_pkg.sv
package susp_pkg;
    localparam logic [7:0] ADDR_PMEN    = 8'h80;
    localparam logic [7:0] ADDR_IRQ_SPD = 8'h8C;
    localparam logic [7:0] ADDR_VID_SPD = 8'h8D;
    localparam logic [7:0] ADDR_RUN     = 8'h94;
    localparam logic [7:0] ADDR_SUSP    = 8'h95;
    localparam logic [7:0] ADDR_CFG     = 8'h96;

    localparam int CFG_EN_BIT  = 0;
    localparam int PM_IRQ_BIT  = 3;
    localparam int PM_VID_BIT  = 4;
    localparam int NUM_SPDUP   = 2;

    typedef enum logic {PH_RUN = 1'b0, PH_SUSP = 1'b1} phase_e;

    typedef struct packed {
        logic [7:0] pmen;
        logic [7:0] irq_spd;
        logic [7:0] vid_spd;
        logic [7:0] run_cnt;
        logic [7:0] susp_cnt;
        logic [7:0] cfg;
    } regs_t;
endpackage

// File: rtl/susp_tick.sv
module susp_tick #(
    parameter int DIV = 1000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int W = (DIV > 1) ? $clog2(DIV) : 1;

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = (cnt_q == W'(DIV - 1));
        cnt_d = tick ? '0 : cnt_q + W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/susp_speedup.sv
module susp_speedup #(
    parameter int MS_TICKS = 31,
    parameter int CW       = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic          event_i,
    input  logic          tick,
    input  logic [CW-1:0] reload,
    output logic          active
);
    localparam int SW = (MS_TICKS > 1) ? $clog2(MS_TICKS) : 1;

    typedef struct packed {
        logic [CW-1:0] ms;
        logic [SW-1:0] sub;
    } win_t;

    win_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (!enable) begin
            s_d = '0;
        end else if (event_i && (reload != '0)) begin
            s_d.ms  = reload;
            s_d.sub = SW'(MS_TICKS - 1);
        end else if (tick && (s_q.ms != '0)) begin
            if (s_q.sub == '0) begin
                s_d.ms  = s_q.ms - CW'(1);
                s_d.sub = SW'(MS_TICKS - 1);
            end else begin
                s_d.sub = s_q.sub - SW'(1);
            end
        end
        active = (s_q.ms != '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/susp_phase.sv
module susp_phase
    import susp_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic          tick,
    input  logic [CW-1:0] run_reg,
    input  logic [CW-1:0] susp_reg,
    output logic          suspend,
    output logic          latch,
    output logic [CW-1:0] cur_run,
    output logic [CW-1:0] cur_susp
);
    typedef struct packed {
        phase_e        phase;
        logic [CW-1:0] remain;
        logic [CW-1:0] run_len;
        logic [CW-1:0] susp_len;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d   = s_q;
        latch = 1'b0;
        if (!enable) begin
            s_d = '0;
        end else if (tick) begin
            if (s_q.remain > CW'(1)) begin
                s_d.remain = s_q.remain - CW'(1);
            end else if ((s_q.phase == PH_RUN) && (s_q.susp_len != '0)) begin
                s_d.phase  = PH_SUSP;
                s_d.remain = s_q.susp_len;
            end else begin
                latch        = 1'b1;
                s_d.run_len  = run_reg;
                s_d.susp_len = susp_reg;
                if (run_reg != '0) begin
                    s_d.phase  = PH_RUN;
                    s_d.remain = run_reg;
                end else if (susp_reg != '0) begin
                    s_d.phase  = PH_SUSP;
                    s_d.remain = susp_reg;
                end else begin
                    s_d.phase  = PH_RUN;
                    s_d.remain = '0;
                end
            end
        end
        suspend  = enable && (s_q.phase == PH_SUSP);
        cur_run  = s_q.run_len;
        cur_susp = s_q.susp_len;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/susp_duty_ctrl.sv
module susp_duty_ctrl
    import susp_pkg::*;
#(
    parameter int TICK_DIV = 1000,
    parameter int MS_TICKS = 31
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_wr,
    input  logic [7:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic       irq_evt,
    input  logic       vid_evt,
    output logic       susp_n
);
    regs_t regs_d, regs_q;

    logic       tick;
    logic       mod_en;
    logic       suspend;
    logic       latch;
    logic [7:0] cur_run, cur_susp;
    logic       spd_en     [NUM_SPDUP];
    logic       spd_evt    [NUM_SPDUP];
    logic [7:0] spd_reload [NUM_SPDUP];
    logic       spd_act    [NUM_SPDUP];
    logic       spd_any;

    always_comb begin
        regs_d = regs_q;
        if (reg_wr) begin
            case (reg_addr)
                ADDR_PMEN:    regs_d.pmen     = reg_wdata;
                ADDR_IRQ_SPD: regs_d.irq_spd  = reg_wdata;
                ADDR_VID_SPD: regs_d.vid_spd  = reg_wdata;
                ADDR_RUN:     regs_d.run_cnt  = reg_wdata;
                ADDR_SUSP:    regs_d.susp_cnt = reg_wdata;
                ADDR_CFG:     regs_d.cfg      = reg_wdata;
                default:      ;
            endcase
        end
        case (reg_addr)
            ADDR_PMEN:    reg_rdata = regs_q.pmen;
            ADDR_IRQ_SPD: reg_rdata = regs_q.irq_spd;
            ADDR_VID_SPD: reg_rdata = regs_q.vid_spd;
            ADDR_RUN:     reg_rdata = regs_q.run_cnt;
            ADDR_SUSP:    reg_rdata = regs_q.susp_cnt;
            ADDR_CFG:     reg_rdata = regs_q.cfg;
            default:      reg_rdata = 8'h00;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    always_comb begin
        mod_en        = regs_q.cfg[CFG_EN_BIT];
        spd_en[0]     = regs_q.pmen[PM_IRQ_BIT];
        spd_evt[0]    = irq_evt;
        spd_reload[0] = regs_q.irq_spd;
        spd_en[1]     = regs_q.pmen[PM_VID_BIT];
        spd_evt[1]    = vid_evt;
        spd_reload[1] = regs_q.vid_spd;
    end

    susp_tick #(.DIV(TICK_DIV)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick)
    );

    susp_phase #(.CW(8)) u_phase (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (mod_en),
        .tick    (tick),
        .run_reg (regs_q.run_cnt),
        .susp_reg(regs_q.susp_cnt),
        .suspend (suspend),
        .latch   (latch),
        .cur_run (cur_run),
        .cur_susp(cur_susp)
    );

    for (genvar g = 0; g < NUM_SPDUP; g++) begin : g_spd
        susp_speedup #(.MS_TICKS(MS_TICKS), .CW(8)) u_win (
            .clk    (clk),
            .rst_n  (rst_n),
            .enable (spd_en[g]),
            .event_i(spd_evt[g]),
            .tick   (tick),
            .reload (spd_reload[g]),
            .active (spd_act[g])
        );
    end

    always_comb begin
        spd_any = 1'b0;
        for (int i = 0; i < NUM_SPDUP; i++) spd_any = spd_any | spd_act[i];
        susp_n = !(suspend && !spd_any);
    end
endmodule

// File: rtl/susp_duty_chk.sv
module susp_duty_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       susp_n,
    input logic       tick,
    input logic       mod_en,
    input logic       spd_any,
    input logic       latch,
    input logic [7:0] cur_run,
    input logic [7:0] cur_susp,
    input logic       irq_arm,
    input logic       irq_act,
    input logic       vid_arm,
    input logic       vid_act
);
    a_r3_high_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !mod_en |-> susp_n);

    a_r2_edge_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(susp_n) && mod_en && $past(mod_en) && !spd_any && !$past(spd_any))
        |-> $past(tick));

    a_r5_counts_held: assert property (@(posedge clk) disable iff (!rst_n)
        (!latch && mod_en) |=> ($stable(cur_run) && $stable(cur_susp)));

    a_r4_zero_susp_high: assert property (@(posedge clk) disable iff (!rst_n)
        (mod_en && cur_susp == 8'h00) |-> susp_n);

    a_r6_window_high: assert property (@(posedge clk) disable iff (!rst_n)
        spd_any |-> susp_n);

    a_r8_irq_arms: assert property (@(posedge clk) disable iff (!rst_n)
        irq_arm |=> irq_act);

    a_r7_vid_arms: assert property (@(posedge clk) disable iff (!rst_n)
        vid_arm |=> vid_act);
endmodule

bind susp_duty_ctrl susp_duty_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .susp_n  (susp_n),
    .tick    (tick),
    .mod_en  (mod_en),
    .spd_any (spd_any),
    .latch   (latch),
    .cur_run (cur_run),
    .cur_susp(cur_susp),
    .irq_arm (irq_evt && spd_en[0] && (spd_reload[0] != 8'h00)),
    .irq_act (spd_act[0]),
    .vid_arm (vid_evt && spd_en[1] && (spd_reload[1] != 8'h00)),
    .vid_act (spd_act[1])
);

// File: tb/susp_duty_ctrl_test.sv
module susp_duty_ctrl_test;
    localparam int TD = 4;
    localparam int MT = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_addr = 8'h00;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       irq_evt = 1'b0;
    logic       vid_evt = 1'b0;
    logic       susp_n;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    susp_duty_ctrl #(.TICK_DIV(TD), .MS_TICKS(MT)) uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_evt(irq_evt), .vid_evt(vid_evt), .susp_n(susp_n)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_check(input logic [7:0] a, input logic [7:0] exp, input string req);
        @(negedge clk);
        reg_addr = a;
        #1;
        check(reg_rdata == exp, req, int'(reg_rdata), int'(exp));
    endtask

    task automatic sync_rise();
        logic prev;
        prev = susp_n;
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            if (!prev && susp_n) return;
            prev = susp_n;
        end
    endtask

    task automatic run_len(input logic lvl, output int n);
        n = 0;
        while (susp_n == lvl && n < 5000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic count_lvl(input logic lvl, input int win, output int n);
        n = 0;
        for (int i = 0; i < win; i++) begin
            @(negedge clk);
            if (susp_n == lvl) n++;
        end
    endtask

    task automatic pulse(input bit vid);
        @(negedge clk);
        if (vid) vid_evt = 1'b1; else irq_evt = 1'b1;
        @(negedge clk);
        vid_evt = 1'b0; irq_evt = 1'b0;
    endtask

    initial begin : watchdog
        for (int i = 0; i < 150000; i++) begin
            @(posedge clk);
            if (done) disable watchdog;
        end
        fails++; checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int n, h, l;
        int run_set [4] = '{1, 2, 3, 5};
        int susp_set[3] = '{1, 2, 4};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        check(susp_n == 1'b1, "R1 reset susp_n", int'(susp_n), 1);
        rd_check(8'h80, 8'h00, "R1 reset 0x80");
        rd_check(8'h94, 8'h00, "R1 reset 0x94");
        rd_check(8'h96, 8'h00, "R1 reset 0x96");

        // R1: readback and unmapped address
        wr(8'h80, 8'h1F); rd_check(8'h80, 8'h1F, "R1 rb 0x80");
        wr(8'h8C, 8'h33); rd_check(8'h8C, 8'h33, "R1 rb 0x8C");
        wr(8'h8D, 8'h44); rd_check(8'h8D, 8'h44, "R1 rb 0x8D");
        wr(8'h90, 8'hFF); rd_check(8'h90, 8'h00, "R1 unmapped 0x90");
        wr(8'h80, 8'h00);

        // R3: disabled with counts loaded
        wr(8'h94, 8'h01); wr(8'h95, 8'h01);
        count_lvl(1'b0, 40, n);
        check(n == 0, "R3 disabled low cycles", n, 0);
        wr(8'h96, 8'h01);

        // R2: sweep of run/suspend pairs
        foreach (run_set[i]) begin
            foreach (susp_set[j]) begin
                wr(8'h94, 8'(run_set[i]));
                wr(8'h95, 8'(susp_set[j]));
                sync_rise();
                sync_rise();
                run_len(1'b1, h);
                run_len(1'b0, l);
                check(h == run_set[i] * TD, "R2 run phase", h, run_set[i] * TD);
                check(l == susp_set[j] * TD, "R2 suspend phase", l, susp_set[j] * TD);
            end
        end

        // R5: rewrite mid run phase
        wr(8'h94, 8'h05); wr(8'h95, 8'h02);
        sync_rise(); sync_rise();
        repeat (3) @(negedge clk);
        wr(8'h94, 8'h01); wr(8'h95, 8'h01);
        run_len(1'b1, h);
        check(h + 7 == 5 * TD, "R5 old run kept", h + 7, 5 * TD);
        run_len(1'b0, l);
        check(l == 2 * TD, "R5 old suspend kept", l, 2 * TD);
        run_len(1'b1, h);
        run_len(1'b0, l);
        check(h == TD && l == TD, "R5 new counts applied", h + l, 2 * TD);

        // R4: zero counts
        wr(8'h94, 8'h00); wr(8'h95, 8'h03);
        repeat (40) @(negedge clk);
        count_lvl(1'b1, 60, n);
        check(n == 0, "R4 zero run held low", n, 0);
        wr(8'h94, 8'h03); wr(8'h95, 8'h00);
        repeat (40) @(negedge clk);
        count_lvl(1'b0, 60, n);
        check(n == 0, "R4 zero suspend held high", n, 0);

        // R3: disable while throttling
        wr(8'h94, 8'h00); wr(8'h95, 8'h03);
        repeat (40) @(negedge clk);
        wr(8'h96, 8'h00);
        check(susp_n == 1'b1, "R3 disable immediate", int'(susp_n), 1);
        count_lvl(1'b0, 60, n);
        check(n == 0, "R3 disabled stays high", n, 0);
        wr(8'h96, 8'h01);
        repeat (40) @(negedge clk);

        // R6: interrupt window, 2 ms
        wr(8'h80, 8'h08); wr(8'h8C, 8'h02);
        check(susp_n == 1'b0, "R6 throttled before event", int'(susp_n), 0);
        pulse(1'b0);
        run_len(1'b1, h);
        check(h >= 2 * MT * TD - TD + 1 && h <= 2 * MT * TD, "R6 irq window", h, 2 * MT * TD);

        // R8: reload during window
        repeat (5) @(negedge clk);
        pulse(1'b0);
        repeat (9) @(negedge clk);
        pulse(1'b0);
        run_len(1'b1, h);
        check(h + 10 >= 2 * MT * TD + 10 - TD + 1 && h + 10 <= 2 * MT * TD + 10,
              "R8 reload extends", h + 10, 2 * MT * TD + 10);

        // R8: zero count and masked enable
        wr(8'h8C, 8'h00);
        pulse(1'b0);
        count_lvl(1'b1, 30, n);
        check(n == 0, "R8 zero count ignored", n, 0);
        wr(8'h8C, 8'h02); wr(8'h80, 8'h10);
        pulse(1'b0);
        count_lvl(1'b1, 30, n);
        check(n == 0, "R8 masked irq ignored", n, 0);

        // R7: video window, 1 ms
        wr(8'h8D, 8'h01);
        repeat (5) @(negedge clk);
        pulse(1'b1);
        run_len(1'b1, h);
        check(h >= MT * TD - TD + 1 && h <= MT * TD, "R7 video window", h, MT * TD);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule